// File: doc/BRIEF.md
# Contiguous-Range Multicast Switch Slice

This block is one stage of a four-port packet switch that replicates a packet to a run of adjacent output ports. The first flit of each packet is a header. Its two lowest 2-bit fields name the first and the last output of the run. Every flit of the packet, the header included, is then sent to all outputs of that run in the same cycle. Each output returns a 2-bit acknowledgement on its own return lane. The block merges these into one result, sent back on the lane of the input that sent the packet. The most severe status wins the merge.

Only one multicast circuit is open at a time. An input whose header wins arbitration owns the circuit. The owner keeps it until its end-of-packet flit has passed and the merged acknowledgement has been sent. Only then can another header be granted. A header whose first port is above its last port is not forwarded. The block consumes the whole packet and answers it with a network-error acknowledgement.

Top module: `mcs_switch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, in_ready, out_valid and src_ack_valid are all zero, even with a header waiting.
- R2: The header is decoded as first port = data[1:0] and last port = data[3:2]. Every flit of the granted packet appears on exactly the outputs first..last, with the owner's data and last bit on each of them.
- R3: A flit is offered only when every output in the run is ready. While any of them is not ready, out_valid and in_ready are both zero. Ready on outputs outside the run has no effect.
- R4: While the circuit is open, no other input is granted. This holds until the owner's end-of-packet flit has been transferred and the merged acknowledgement has been sent. When several headers wait, the lowest-numbered input wins.
- R5: Status codes are 00 success, 01 unsuccessful and 10 network error. The merged result is the most severe returned status, so 10 beats 01, which beats 00. A returned 11 counts as network error and is reported as 10.
- R6: The merged acknowledgement goes out as a one-cycle pulse on the owner's lane only. It becomes visible in the cycle after the later of two events: the end-of-packet transfer, or the last outstanding in-range acknowledgement.
- R7: Acknowledgements from outputs outside the run, or returned while no circuit is open, have no effect on any merged result.
- R8: A header with first port > last port drives no output. The packet's flits are consumed until its last flit. A 10 acknowledgement follows in the next cycle.
- R9: A header presented while no circuit is open appears on its outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_PORTS | Flit valid per input |
| in_ready | output | NUM_PORTS | Flit accepted per input |
| in_data | input | NUM_PORTS*DATA_W | Flit data, input i at [i*DATA_W +: DATA_W] |
| in_last | input | NUM_PORTS | End-of-packet marker per input |
| out_valid | output | NUM_PORTS | Flit valid per output |
| out_ready | input | NUM_PORTS | Output can take a flit |
| out_data | output | NUM_PORTS*DATA_W | Flit data per output |
| out_last | output | NUM_PORTS | End-of-packet marker per output |
| ret_valid | input | NUM_PORTS | Acknowledgement returned by output o |
| ret_status | input | 2*NUM_PORTS | Returned status, output o at [2o+1:2o] |
| src_ack_valid | output | NUM_PORTS | Merged acknowledgement pulse toward input i |
| src_ack_status | output | 2*NUM_PORTS | Merged status, input i at [2i+1:2i] |

## Verification
Flits leave combinationally in the same cycle they are offered. A header appears on its outputs one cycle after it is first presented, because the grant is registered. The merged acknowledgement is registered and shows one cycle after the later of the end-of-packet transfer and the final in-range return. A dropped packet's error shows one cycle after its last flit is consumed. Every task drives inputs just after a falling edge and samples one time unit later. Each expected value is therefore read in exactly the cycle counted from these rules. The bench also reads the cycles before it, to show nothing appears early.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef logic [1:0] ack_t;

    localparam ack_t ACK_OK  = 2'b00;
    localparam ack_t ACK_NAK = 2'b01;
    localparam ack_t ACK_ERR = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_DROP = 2'd2
    } state_e;

    // Severity of a returned code; the reserved code counts as an error.
    function automatic ack_t ack_rank(input ack_t s);
        return (s == 2'b11) ? ACK_ERR : s;
    endfunction

    function automatic ack_t ack_worse(input ack_t a, input ack_t b);
        ack_t ra;
        ack_t rb;
        ra = ack_rank(a);
        rb = ack_rank(b);
        return (ra > rb) ? ra : rb;
    endfunction

endpackage

// File: rtl/mcs_grant.sv
module mcs_grant #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          gnt_any,
    output logic [IW-1:0] gnt_idx
);
    // Fixed priority: the lowest-numbered requester wins.
    always_comb begin
        gnt_any = |req;
        gnt_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mcs_range_decode.sv
module mcs_range_decode #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [IW-1:0] first_port,
    input  logic [IW-1:0] last_port,
    output logic [N-1:0]  mask,
    output logic          bad
);
    assign bad = first_port > last_port;

    for (genvar o = 0; o < N; o++) begin : g_lane
        assign mask[o] = (IW'(o) >= first_port) && (IW'(o) <= last_port);
    end
endmodule

// File: rtl/mcs_ack_merge.sv
module mcs_ack_merge
    import mcs_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]   sel,
    input  logic [N-1:0]   ret_valid,
    input  logic [2*N-1:0] ret_status,
    input  logic [N-1:0]   seen_q,
    input  ack_t           worst_q,
    output logic [N-1:0]   seen_nx,
    output ack_t           worst_nx,
    output logic           all_seen
);
    logic [N-1:0] take;

    assign take     = ret_valid & sel;
    assign seen_nx  = seen_q | take;
    assign all_seen = ((seen_nx & sel) == sel);

    always_comb begin
        worst_nx = worst_q;
        for (int o = 0; o < N; o++) begin
            if (take[o]) begin
                worst_nx = ack_worse(worst_nx, ret_status[2*o +: 2]);
            end
        end
    end
endmodule

// File: rtl/mcs_switch.sv
module mcs_switch
    import mcs_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int DATA_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        in_valid,
    output logic [NUM_PORTS-1:0]        in_ready,
    input  logic [NUM_PORTS*DATA_W-1:0] in_data,
    input  logic [NUM_PORTS-1:0]        in_last,
    output logic [NUM_PORTS-1:0]        out_valid,
    input  logic [NUM_PORTS-1:0]        out_ready,
    output logic [NUM_PORTS*DATA_W-1:0] out_data,
    output logic [NUM_PORTS-1:0]        out_last,
    input  logic [NUM_PORTS-1:0]        ret_valid,
    input  logic [2*NUM_PORTS-1:0]      ret_status,
    output logic [NUM_PORTS-1:0]        src_ack_valid,
    output logic [2*NUM_PORTS-1:0]      src_ack_status
);
    localparam int N  = NUM_PORTS;
    localparam int W  = DATA_W;
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        state_e         st;
        logic [IW-1:0]  owner;
        logic [N-1:0]   mask;
        logic [N-1:0]   seen;
        logic           eop;
        ack_t           worst;
        logic [N-1:0]   sack_v;
        ack_t           sack_s;
    } ctl_t;

    ctl_t q, d;

    // ---------------- arbitration and header decode ----------------
    logic [N-1:0]  gnt_req;
    logic          gnt_any;
    logic [IW-1:0] gnt_idx;
    logic [W-1:0]  hdr_word;
    logic [N-1:0]  dec_mask;
    logic          dec_bad;

    assign gnt_req = (q.st == ST_IDLE) ? in_valid : '0;

    mcs_grant #(.N(N), .IW(IW)) u_grant (
        .req     (gnt_req),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx)
    );

    always_comb begin
        hdr_word = in_data[gnt_idx*W +: W];
    end

    mcs_range_decode #(.N(N), .IW(IW)) u_range (
        .first_port (hdr_word[IW-1:0]),
        .last_port  (hdr_word[2*IW-1:IW]),
        .mask       (dec_mask),
        .bad        (dec_bad)
    );

    // ---------------- owner flit path ----------------
    logic [W-1:0] own_data;
    logic         own_valid;
    logic         own_last;
    logic [N-1:0] owner_oh;
    logic         all_ready;
    logic         fwd_open;
    logic         drop_open;
    logic         xfer_last;

    always_comb begin
        own_data  = in_data[q.owner*W +: W];
        own_valid = in_valid[q.owner];
        own_last  = in_last[q.owner];
    end

    assign owner_oh  = {{(N-1){1'b0}}, 1'b1} << q.owner;
    assign all_ready = &(out_ready | ~q.mask);
    assign fwd_open  = (q.st == ST_FWD) && !q.eop && all_ready;
    assign drop_open = (q.st == ST_DROP) && !q.eop;
    assign in_ready  = (fwd_open || drop_open) ? owner_oh : '0;
    assign xfer_last = (fwd_open || drop_open) && own_valid && own_last;
    assign out_valid = (fwd_open && own_valid) ? q.mask : '0;

    for (genvar o = 0; o < N; o++) begin : g_out
        assign out_data[o*W +: W] = own_data;
        assign out_last[o]        = own_last;
    end

    // ---------------- acknowledgement merge ----------------
    logic [N-1:0] merge_sel;
    logic [N-1:0] seen_nx;
    ack_t         worst_nx;
    logic         all_seen;

    assign merge_sel = (q.st == ST_IDLE) ? '0 : q.mask;

    mcs_ack_merge #(.N(N)) u_merge (
        .sel        (merge_sel),
        .ret_valid  (ret_valid),
        .ret_status (ret_status),
        .seen_q     (q.seen),
        .worst_q    (q.worst),
        .seen_nx    (seen_nx),
        .worst_nx   (worst_nx),
        .all_seen   (all_seen)
    );

    for (genvar i = 0; i < N; i++) begin : g_src
        assign src_ack_status[2*i +: 2] = q.sack_v[i] ? q.sack_s : ACK_OK;
    end
    assign src_ack_valid = q.sack_v;

    // ---------------- next-state ----------------
    always_comb begin
        d        = q;
        d.sack_v = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (gnt_any) begin
                    d.owner = gnt_idx;
                    d.mask  = dec_bad ? '0 : dec_mask;
                    d.seen  = '0;
                    d.eop   = 1'b0;
                    d.worst = dec_bad ? ACK_ERR : ACK_OK;
                    d.st    = dec_bad ? ST_DROP : ST_FWD;
                end
            end
            default: begin
                d.seen  = seen_nx;
                d.worst = worst_nx;
                d.eop   = q.eop | xfer_last;
                if (d.eop && all_seen) begin
                    d.sack_v = owner_oh;
                    d.sack_s = worst_nx;
                    d.st     = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/mcs_switch_chk.sv
module mcs_switch_chk #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   in_ready,
    input logic [N-1:0]   out_valid,
    input logic [N-1:0]   out_ready,
    input logic [N-1:0]   src_ack_valid,
    input logic [2*N-1:0] src_ack_status
);
    logic [N-1:0] ov_low;
    logic         reserved_seen;

    assign ov_low = out_valid & ((~out_valid) + {{(N-1){1'b0}}, 1'b1});

    always_comb begin
        reserved_seen = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (src_ack_valid[i] && src_ack_status[2*i +: 2] == 2'b11) begin
                reserved_seen = 1'b1;
            end
        end
    end

    // R2: outputs driven together always form one adjacent run
    a_r2_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid + ov_low) & out_valid) == '0);

    // R3: no output is offered a flit unless it is ready
    a_r3_all_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid & ~out_ready) == '0);

    // R3: an offered flit is always being taken from exactly one input
    a_r3_owner_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid != '0) |-> ($countones(in_ready) == 1));

    // R4: at most one input owns the circuit
    a_r4_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));

    // R5: the reserved code never leaves the block
    a_r5_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        !reserved_seen);

    // R6: merged acknowledgement goes to one lane as a single-cycle pulse
    a_r6_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ack_valid));

    a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ack_valid != '0) |=> (src_ack_valid == '0));

endmodule

bind mcs_switch mcs_switch_chk #(.N(NUM_PORTS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .src_ack_valid  (src_ack_valid),
    .src_ack_status (src_ack_status)
);

// File: tb/mcs_switch_tb.sv
`timescale 1ns/1ps
module mcs_switch_tb;
    localparam int N = 4;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   in_valid = '0;
    logic [N-1:0]   in_ready;
    logic [N*W-1:0] in_data = '0;
    logic [N-1:0]   in_last = '0;
    logic [N-1:0]   out_valid;
    logic [N-1:0]   out_ready = '1;
    logic [N*W-1:0] out_data;
    logic [N-1:0]   out_last;
    logic [N-1:0]   ret_valid = '0;
    logic [2*N-1:0] ret_status = '0;
    logic [N-1:0]   src_ack_valid;
    logic [2*N-1:0] src_ack_status;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mcs_switch #(.NUM_PORTS(N), .DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .ret_valid(ret_valid), .ret_status(ret_status),
        .src_ack_valid(src_ack_valid), .src_ack_status(src_ack_status)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] hdr(input int lo, input int hi, input int tag);
        return {tag[11:0], hi[1:0], lo[1:0]};
    endfunction

    function automatic logic [N-1:0] run_mask(input int lo, input int hi);
        logic [N-1:0] m;
        m = '0;
        for (int o = 0; o < N; o++) if (o >= lo && o <= hi) m[o] = 1'b1;
        return m;
    endfunction

    function automatic logic [1:0] sev(input logic [1:0] s);
        return (s == 2'b11) ? 2'b10 : s;
    endfunction

    function automatic logic [1:0] expect_ack(input logic [7:0] stat, input logic [N-1:0] m);
        logic [1:0] w;
        w = 2'b00;
        for (int o = 0; o < N; o++)
            if (m[o] && sev(stat[2*o +: 2]) > w) w = sev(stat[2*o +: 2]);
        return w;
    endfunction

    task automatic put(input int s, input logic v, input logic [W-1:0] dat, input logic l);
        in_valid[s]        = v;
        in_data[s*W +: W]  = dat;
        in_last[s]         = l;
    endtask

    // One multicast from input s; every return lane answers with stat.
    task automatic run_packet(input int s, input int lo, input int hi, input int nfl,
                              input logic [7:0] stat, input string req);
        logic [N-1:0] m;
        logic [W-1:0] word;
        m = run_mask(lo, hi);
        put(s, 1'b1, hdr(lo, hi, s + 16), nfl == 1);
        @(negedge clk);
        for (int k = 0; k < nfl; k++) begin
            word = (k == 0) ? hdr(lo, hi, s + 16) : W'(16'hC000 | (s << 8) | k);
            if (k > 0) put(s, 1'b1, word, k == nfl - 1);
            #1;
            check(req, "out_valid", out_valid, m);
            check(req, "data first lane", out_data[lo*W +: W], word);
            check(req, "data last lane", out_data[hi*W +: W], word);
            check(req, "last bit", out_last[lo], k == nfl - 1);
            check(req, "in_ready", in_ready, 1 << s);
            @(negedge clk);
        end
        put(s, 1'b0, '0, 1'b0);
        ret_valid  = '1;
        ret_status = stat;
        #1;
        check(req, "no early ack", src_ack_valid, '0);
        @(negedge clk);
        ret_valid = '0;
        #1;
        check(req, "ack lane", src_ack_valid, 1 << s);
        check(req, "ack status", src_ack_status[2*s +: 2], expect_ack(stat, m));
        @(negedge clk);
        #1;
        check("R6", "ack pulse ends", src_ack_valid, '0);
    endtask

    task automatic t_reset;
        put(0, 1'b1, hdr(0, 3, 1), 1'b1);
        repeat (3) @(negedge clk);
        #1;
        check("R1", "in_ready in reset", in_ready, '0);
        check("R1", "out_valid in reset", out_valid, '0);
        check("R1", "ack in reset", src_ack_valid, '0);
        rst_n = 1'b1;
        put(0, 1'b0, '0, 1'b0);
        @(negedge clk);
        #1;
        check("R1", "out_valid after reset", out_valid, '0);
        check("R1", "ack after reset", src_ack_valid, '0);
    endtask

    // R2, R7, R9: every run; out-of-run lanes return errors that must be ignored
    task automatic t_all_ranges;
        logic [7:0] stat;
        for (int lo = 0; lo < N; lo++) begin
            for (int hi = lo; hi < N; hi++) begin
                stat = '0;
                for (int o = 0; o < N; o++)
                    if (!(o >= lo && o <= hi)) stat[2*o +: 2] = 2'b10;
                run_packet((lo + hi) % N, lo, hi, 2, stat, "R2 R7 R9");
            end
        end
    endtask

    // R5: every mix of four returned codes over the full run
    task automatic t_ack_mix;
        for (int c = 0; c < 256; c++) begin
            run_packet(c % N, 0, 3, 1, 8'(c), "R5");
        end
    endtask

    // R6: merged result waits for the later of EOP and the final return
    task automatic t_stagger;
        put(0, 1'b1, hdr(0, 3, 5), 1'b0);
        @(negedge clk);
        ret_valid = 4'b0011; ret_status = 8'b00_00_01_00;
        #1;
        check("R6", "flit out", out_valid, 4'hF);
        @(negedge clk);
        ret_valid = 4'b0100; ret_status = 8'b00_00_00_00;
        put(0, 1'b1, 16'h1234, 1'b1);
        #1;
        check("R6", "no ack before EOP", src_ack_valid, '0);
        @(negedge clk);
        ret_valid = '0;
        put(0, 1'b0, '0, 1'b0);
        #1;
        check("R6", "no ack while lane 3 owes", src_ack_valid, '0);
        check("R6", "nothing forwarded after EOP", out_valid, '0);
        @(negedge clk);
        #1;
        check("R6", "still waiting", src_ack_valid, '0);
        ret_valid = 4'b1000; ret_status = 8'b10_00_00_00;
        @(negedge clk);
        ret_valid = '0;
        #1;
        check("R6", "late ack lane", src_ack_valid, 4'b0001);
        check("R6", "late ack status", src_ack_status[1:0], 2'b10);
        @(negedge clk);
        // all returns before EOP
        put(0, 1'b1, hdr(0, 3, 6), 1'b0);
        @(negedge clk);
        ret_valid = 4'hF; ret_status = 8'b00_01_00_00;
        #1;
        check("R6", "no ack on header", src_ack_valid, '0);
        @(negedge clk);
        ret_valid = '0;
        put(0, 1'b1, 16'h4321, 1'b1);
        #1;
        check("R6", "no ack before EOP", src_ack_valid, '0);
        @(negedge clk);
        put(0, 1'b0, '0, 1'b0);
        #1;
        check("R6", "ack after EOP", src_ack_valid, 4'b0001);
        check("R6", "ack status", src_ack_status[1:0], 2'b01);
        @(negedge clk);
    endtask

    // R3: stall while a run member is not ready; outside lanes do not matter
    task automatic t_backpressure;
        out_ready = 4'b1010;
        put(2, 1'b1, hdr(1, 2, 7), 1'b1);
        @(negedge clk);
        #1;
        check("R3", "stalled out_valid", out_valid, '0);
        check("R3", "stalled in_ready", in_ready, '0);
        @(negedge clk);
        #1;
        check("R3", "still stalled", out_valid, '0);
        out_ready = 4'b0110;
        #1;
        check("R3", "released out_valid", out_valid, 4'b0110);
        check("R3", "released in_ready", in_ready, 4'b0100);
        @(negedge clk);
        put(2, 1'b0, '0, 1'b0);
        out_ready = '1;
        ret_valid = 4'b0110; ret_status = '0;
        @(negedge clk);
        ret_valid = '0;
        #1;
        check("R3", "ack after stall", src_ack_valid, 4'b0100);
        @(negedge clk);
    endtask

    // R4: two waiting headers, lowest wins, second waits for EOP and ack
    task automatic t_serial;
        put(1, 1'b1, hdr(0, 1, 8), 1'b0);
        put(2, 1'b1, hdr(2, 3, 9), 1'b1);
        @(negedge clk);
        #1;
        check("R4", "priority owner", in_ready, 4'b0010);
        check("R4", "first run", out_valid, 4'b0011);
        check("R4", "first data", out_data[0 +: W], hdr(0, 1, 8));
        @(negedge clk);
        put(1, 1'b1, 16'h00AA, 1'b1);
        #1;
        check("R4", "second held mid-packet", in_ready, 4'b0010);
        @(negedge clk);
        put(1, 1'b0, '0, 1'b0);
        ret_valid = 4'b0011; ret_status = '0;
        #1;
        check("R4", "held after EOP, ack owed", out_valid, '0);
        check("R4", "held in_ready", in_ready, '0);
        @(negedge clk);
        ret_valid = '0;
        #1;
        check("R4", "first ack", src_ack_valid, 4'b0010);
        check("R4", "not yet granted", out_valid, '0);
        @(negedge clk);
        #1;
        check("R4", "second run", out_valid, 4'b1100);
        check("R4", "second owner", in_ready, 4'b0100);
        check("R4", "second data", out_data[2*W +: W], hdr(2, 3, 9));
        @(negedge clk);
        put(2, 1'b0, '0, 1'b0);
        ret_valid = 4'b1100; ret_status = 8'b01_01_00_00;
        @(negedge clk);
        ret_valid = '0;
        #1;
        check("R4", "second ack lane", src_ack_valid, 4'b0100);
        check("R4", "second ack status", src_ack_status[5:4], 2'b01);
        @(negedge clk);
    endtask

    // R8: reversed run is drained and answered with an error
    task automatic t_bad_range;
        put(3, 1'b1, hdr(3, 1, 10), 1'b0);
        @(negedge clk);
        #1;
        check("R8", "header consumed", in_ready, 4'b1000);
        check("R8", "no output", out_valid, '0);
        @(negedge clk);
        put(3, 1'b1, 16'h0BAD, 1'b1);
        #1;
        check("R8", "tail consumed", in_ready, 4'b1000);
        check("R8", "no ack yet", src_ack_valid, '0);
        @(negedge clk);
        put(3, 1'b0, '0, 1'b0);
        #1;
        check("R8", "error ack lane", src_ack_valid, 4'b1000);
        check("R8", "error ack status", src_ack_status[7:6], 2'b10);
        check("R8", "still no output", out_valid, '0);
        @(negedge clk);
    endtask

    // R7: returns while idle leave no trace
    task automatic t_idle_returns;
        ret_valid = 4'hF; ret_status = 8'hAA;
        @(negedge clk);
        #1;
        check("R7", "no ack from idle returns", src_ack_valid, '0);
        @(negedge clk);
        ret_valid = '0;
        #1;
        check("R7", "no ack later", src_ack_valid, '0);
        run_packet(1, 0, 0, 1, 8'b10_10_10_00, "R7");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_all_ranges();
        t_ack_mix();
        t_stagger();
        t_backpressure();
        t_serial();
        t_bad_range();
        t_idle_returns();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule